// File: doc/BRIEF.md
# Window Watchdog Supervisor with Enable Gating

This block supervises a processor through a window watchdog. After power-up, or after a supply fault, it holds the reset output low for a power-on delay. It then runs repeating cycles. Each cycle is a closed window followed by an open window. Software must produce one falling edge on the service input while the open window is running. A falling edge inside the open window starts a fresh closed window and no reset is issued.

A service edge that arrives during the closed window counts as too early. An open window that ends with no service counts as too late. In both cases the block drives a short reset pulse and then begins a new closed window. If software never services the block, the reset output becomes a periodic square wave.

A separate active-low enable output lets critical loads be powered only after software has shown it is healthy. Enable asserts only after three services in a row have landed in the open window. It drops whenever reset is active.

An undervoltage flag from an external comparator is filtered over a number of clock cycles. Once it passes the filter, it overrides all of the timing. All durations are parameters counted in clock cycles.

Top module: `wdog_window_sup`

## Requirements
- R1: After `rst_n` is released, `rst_out_n` stays low and `en_out_n` stays high for POR_CYC cycles. Service edges during this delay have no effect: the power-on delay still ends after exactly POR_CYC cycles.
- R2: When the power-on delay ends, `rst_out_n` goes high. A closed window of CLOSED_CYC cycles follows, then an open window of OPEN_CYC cycles.
- R3: A service event during the open window produces no reset pulse and starts a new closed window.
- R4: A service event during the closed window drives `rst_out_n` low for one reset pulse, then starts a new closed window.
- R5: If the open window expires with no service event, `rst_out_n` goes low for one reset pulse, then a new closed window starts.
- R6: The reset pulse lasts PULSE_CYC = (CLOSED_CYC + OPEN_CYC) / 40 cycles, rounded down, with a minimum of 1.
- R7: With no service at all, `rst_out_n` repeats with period CLOSED_CYC + OPEN_CYC + PULSE_CYC.
- R8: A service event is a falling edge of `svc_in`. The input passes through a two-flop synchronizer and one edge-detect stage. A falling edge driven just after clock edge m therefore acts on the state at clock edge m+3. A rising edge has no effect.
- R9: `en_out_n` goes low only after GOOD_SVC (default 3) consecutive in-window services. It is high whenever `rst_out_n` is low. Further in-window services keep it low.
- R10: The consecutive-service count returns to zero on any early service, timeout or undervoltage trip. Enable then needs a full run of GOOD_SVC new in-window services.
- R11: If `uv_in` is high for UV_FILT_CYC consecutive cycles, then on the next cycle `rst_out_n` goes low and `en_out_n` goes high. A shorter high pulse on `uv_in` has no effect.
- R12: After an undervoltage trip, the block stays in the power-on delay while `uv_in` remains high. Service edges are ignored. The full POR_CYC delay restarts once the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset of the block |
| svc_in | input | 1 | Service input; a falling edge services the watchdog |
| uv_in | input | 1 | Undervoltage flag from the supply comparator, high when supply is low |
| rst_out_n | output | 1 | Active-low reset to the supervised system |
| en_out_n | output | 1 | Active-low system enable |

## Verification
The bench services the block on the last permitted cycles of a window, services it early, and lets it time out. It checks the exact cycles where the reset pulse starts and ends. A design that treated an early edge as valid would miss the pulse at cycle 603. A miscounted pulse width would leave reset low at the wrong cycle.

Enable is checked after one and two services that follow an early service and a timeout. A design that failed to clear the consecutive count would assert enable too soon. Enable is also checked for staying low through a fourth service. A design that let the count wrap would drop enable at that point.

Undervoltage is tested with a pulse one cycle shorter than the filter, and then with a sustained flag that carries a service edge inside it. A design that did not filter the flag, or that accepted service during the power-on delay, would trip or release reset at the wrong cycle.

// File: rtl/wdog_window_sup.sv
module wdog_window_sup #(
  parameter int POR_CYC     = 1000,
  parameter int CLOSED_CYC  = 800,
  parameter int OPEN_CYC    = 800,
  parameter int UV_FILT_CYC = 50,
  parameter int GOOD_SVC    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic svc_in,
  input  logic uv_in,
  output logic rst_out_n,
  output logic en_out_n
);
  localparam int PULSE_RAW = (CLOSED_CYC + OPEN_CYC) / 40;
  localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : PULSE_RAW;
  localparam int M1   = (POR_CYC > CLOSED_CYC) ? POR_CYC : CLOSED_CYC;
  localparam int M2   = (OPEN_CYC > PULSE_CYC) ? OPEN_CYC : PULSE_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int UW   = $clog2(UV_FILT_CYC + 1);
  localparam int GW   = $clog2(GOOD_SVC + 1);

  localparam logic [1:0] ST_POR = 2'd0;
  localparam logic [1:0] ST_CLS = 2'd1;
  localparam logic [1:0] ST_OPN = 2'd2;
  localparam logic [1:0] ST_PUL = 2'd3;

  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic [GW-1:0] good;
  logic [UW-1:0] uv_cnt;
  logic          s1, s2, s3;
  logic          svc_fall, uv_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= svc_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign svc_fall = s3 & ~s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          uv_cnt <= '0;
    else if (!uv_in)     uv_cnt <= '0;
    else if (!uv_trip)   uv_cnt <= uv_cnt + 1'b1;
  end

  assign uv_trip = (uv_cnt == UW'(UV_FILT_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_POR;
      cnt  <= '0;
      good <= '0;
    end else if (uv_trip) begin
      st   <= ST_POR;
      cnt  <= '0;
      good <= '0;
    end else begin
      case (st)
        ST_POR: begin
          if (cnt == CW'(POR_CYC - 1)) begin
            st  <= ST_CLS;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CLS: begin
          if (svc_fall) begin
            st   <= ST_PUL;
            cnt  <= '0;
            good <= '0;
          end else if (cnt == CW'(CLOSED_CYC - 1)) begin
            st  <= ST_OPN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_OPN: begin
          if (svc_fall) begin
            st  <= ST_CLS;
            cnt <= '0;
            if (good != GW'(GOOD_SVC)) good <= good + 1'b1;
          end else if (cnt == CW'(OPEN_CYC - 1)) begin
            st   <= ST_PUL;
            cnt  <= '0;
            good <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(PULSE_CYC - 1)) begin
            st  <= ST_CLS;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign rst_out_n = (st == ST_CLS) || (st == ST_OPN);
  assign en_out_n  = ~(rst_out_n && (good == GW'(GOOD_SVC)));
endmodule

module wdog_window_sup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] st,
  input logic       svc_fall,
  input logic       uv_trip,
  input logic       rst_out_n,
  input logic       en_out_n
);
  // R9
  en_off_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> en_out_n);

  // R11
  uv_forces_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_trip |=> (!rst_out_n && en_out_n));

  // R4
  early_svc_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && svc_fall && !uv_trip) |=> !rst_out_n);

  // R3
  good_svc_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && svc_fall && !uv_trip) |=> rst_out_n);

  // R9
  en_needs_good_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_out_n) |-> $past(st == 2'd2 && svc_fall));

  // R12
  uv_holds_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_trip |=> (st == 2'd0));
endmodule

bind wdog_window_sup wdog_window_sup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .svc_fall(svc_fall),
  .uv_trip(uv_trip), .rst_out_n(rst_out_n), .en_out_n(en_out_n)
);

// File: tb/sim_wdog_window_sup.sv
module sim_wdog_window_sup;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic svc_in = 1'b1;
  logic uv_in = 1'b0;
  logic rst_out_n, en_out_n;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit live = 0;
  bit done = 0;

  typedef struct {
    int    c;
    bit    r;
    bit    e;
    string tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  wdog_window_sup #(
    .POR_CYC(20), .CLOSED_CYC(60), .OPEN_CYC(60), .UV_FILT_CYC(5), .GOOD_SVC(3)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .svc_in(svc_in), .uv_in(uv_in),
    .rst_out_n(rst_out_n), .en_out_n(en_out_n)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic exp_at(input int c, input bit r, input bit e, input string tag);
    item_t it;
    it.c = c; it.r = r; it.e = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic service(input int m);
    wait_cyc(m);
    svc_in = 1'b0;
    repeat (4) @(negedge clk);
    svc_in = 1'b1;
  endtask

  always @(negedge clk) begin
    if (live) begin
      while (q.size() > 0 && q[0].c == cyc) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (rst_out_n !== it.r || en_out_n !== it.e) begin
          n_bad++;
          $display("FAIL %s cyc %0d: rst_out_n/en_out_n = %b/%b, expected %b/%b",
                   it.tag, cyc, rst_out_n, en_out_n, it.r, it.e);
        end
      end
    end
  end

  initial begin
    exp_at(0, 0, 1, "R1");
    exp_at(10, 0, 1, "R1");
    exp_at(19, 0, 1, "R1");
    exp_at(20, 1, 1, "R2");
    exp_at(79, 1, 1, "R2");
    exp_at(139, 1, 1, "R5");
    exp_at(140, 0, 1, "R5");
    exp_at(142, 0, 1, "R6");
    exp_at(143, 1, 1, "R6");
    exp_at(262, 1, 1, "R7");
    exp_at(263, 0, 1, "R7");
    exp_at(265, 0, 1, "R7");
    exp_at(266, 1, 1, "R7");
    exp_at(386, 1, 1, "R3");
    exp_at(450, 1, 1, "R9");
    exp_at(502, 1, 1, "R9");
    exp_at(503, 1, 0, "R9");
    exp_at(590, 1, 0, "R9");
    exp_at(602, 1, 0, "R8");
    exp_at(603, 0, 1, "R8");
    exp_at(603, 0, 1, "R4");
    exp_at(605, 0, 1, "R6");
    exp_at(606, 1, 1, "R4");
    exp_at(700, 1, 1, "R10");
    exp_at(802, 1, 1, "R5");
    exp_at(803, 0, 1, "R5");
    exp_at(806, 1, 1, "R5");
    exp_at(970, 1, 1, "R10");
    exp_at(1043, 1, 0, "R9");
    exp_at(1090, 1, 0, "R11");
    exp_at(1105, 1, 0, "R11");
    exp_at(1106, 0, 1, "R11");
    exp_at(1130, 0, 1, "R12");
    exp_at(1160, 0, 1, "R12");
    exp_at(1170, 0, 1, "R12");
    exp_at(1171, 1, 1, "R12");

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live  = 1'b1;

    service(5);
    service(340);
    service(420);
    service(500);
    service(580);
    service(600);
    service(680);
    service(880);
    service(960);
    service(1040);
    wait_cyc(1080);
    uv_in = 1'b1;
    wait_cyc(1084);
    uv_in = 1'b0;
    wait_cyc(1100);
    uv_in = 1'b1;
    service(1120);
    wait_cyc(1150);
    uv_in = 1'b0;
    service(1155);
    wait_cyc(1200);

    if (q.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL scoreboard: %0d items not consumed, expected 0", q.size());
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung at cyc %0d, expected end by 1200", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule